// File: doc/BRIEF.md
# Sequential Two's-Complement Word Comparator

This block compares two signed words that arrive one after the other on a single shared input bus. A one-cycle trigger pulse starts a capture sequence. The word on the bus in the cycle after the trigger becomes the first operand, and the word in the following cycle becomes the second. The block then reports whether the first operand is greater than, less than or equal to the second. It has no data output, only the three relation flags and a valid strobe.

Internally the relation comes from an unsigned magnitude compare. A sign-bit correction overrides that result when the two operands have different signs. The result is registered and held, so the control logic can sample it at any point until it issues the next trigger.

A five-state sequencer runs the block:

- `ST_IDLE`: nothing captured since reset.
- `ST_GRAB_A`: capture the first operand.
- `ST_GRAB_B`: capture the second operand.
- `ST_SETTLE`: register the compare result.
- `ST_HOLD`: present the flags.

The transitions are:

- A trigger in any state moves the sequencer to `ST_GRAB_A`.
- Without a trigger, `ST_GRAB_A` moves to `ST_GRAB_B`, `ST_GRAB_B` moves to `ST_SETTLE`, and `ST_SETTLE` moves to `ST_HOLD`.
- Without a trigger, `ST_IDLE` and `ST_HOLD` stay where they are.

Top module: `bus_word_cmp`

## Requirements
- R1: While and directly after reset, `gt_o`, `lt_o`, `eq_o` and `valid_o` are all low.
- R2: Take the trigger as sampled at clock edge E. The bus word sampled at edge E+1 is the first operand and the bus word sampled at edge E+2 is the second; every flag describes first relative to second.
- R3: `valid_o` and the flags update at edge E+3, one cycle after the second capture; between the trigger and that edge `valid_o` is low.
- R4: Whenever `valid_o` is high exactly one of `gt_o`, `lt_o`, `eq_o` is high; whenever `valid_o` is low all three are low.
- R5: When the sign bits (bit WIDTH-1) of the operands match, the flags follow the unsigned magnitude relation of the two words.
- R6: When the first operand is negative (sign bit 1) and the second is non-negative, only `lt_o` is asserted.
- R7: When the first operand is non-negative and the second is negative, only `gt_o` is asserted.
- R8: Bit-identical operands give only `eq_o`.
- R9: Once valid, the flags and `valid_o` stay unchanged whatever the bus carries, until the next trigger.
- R10: A trigger while a capture sequence is in progress abandons it; the next bus word is taken as a fresh first operand and no result of the abandoned sequence is published.
- R11: A trigger sampled while results are valid clears `valid_o` and all flags at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Start pulse for a capture sequence |
| bus_word | input | WIDTH | Shared operand bus |
| gt_o | output | 1 | First operand greater than second |
| lt_o | output | 1 | First operand less than second |
| eq_o | output | 1 | Operands equal |
| valid_o | output | 1 | Flags hold a finished comparison |

## Verification
The bench drives the words just across the sign boundary: most-negative against most-positive, all-ones against zero, and equal negative words. A design that used a plain unsigned compare would invert the result for the mixed-sign pairs. It also swaps operands so that asymmetric pairs expose a design that latched them in the wrong order. It checks that valid stays low until exactly the third edge, so a design that published early or late fails the timing check. It restarts mid-sequence, and a design that kept a stale first operand or published the abandoned result would report the wrong relation.

// File: rtl/cmp_seq_pkg.sv
package cmp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRAB_A,
        ST_GRAB_B,
        ST_SETTLE,
        ST_HOLD
    } cmp_state_t;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_flags_t;

endpackage

// File: rtl/cmp_seq_fsm.sv
module cmp_seq_fsm
    import cmp_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    output cmp_state_t state,
    output logic       cap_a,
    output logic       cap_b,
    output logic       publish
);

    cmp_state_t state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next-state logic: a trigger always restarts the capture
    always_comb begin
        state_nx = state;
        if (trig) begin
            state_nx = ST_GRAB_A;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_GRAB_A: state_nx = ST_GRAB_B;
                ST_GRAB_B: state_nx = ST_SETTLE;
                ST_SETTLE: state_nx = ST_HOLD;
                ST_HOLD:   state_nx = ST_HOLD;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // output decode
    always_comb begin
        cap_a   = 1'b0;
        cap_b   = 1'b0;
        publish = 1'b0;
        unique case (state)
            ST_GRAB_A: cap_a   = !trig;
            ST_GRAB_B: cap_b   = !trig;
            ST_SETTLE: publish = !trig;
            default: ;
        endcase
    end

    // R10
    restart_on_trig_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> (state == ST_GRAB_A));

    // R3
    settle_follows_grab_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE) |-> $past(state == ST_GRAB_B));

endmodule

// File: rtl/cmp_mag_core.sv
module cmp_mag_core
    import cmp_seq_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output cmp_flags_t       rel
);

    localparam int SIGN = WIDTH - 1;

    logic sign_a, sign_b;
    logic u_gt, u_lt, u_eq;

    assign sign_a = op_a[SIGN];
    assign sign_b = op_b[SIGN];

    // plain unsigned magnitude compare
    assign u_gt = op_a > op_b;
    assign u_lt = op_a < op_b;
    assign u_eq = op_a == op_b;

    // sign correction when the operands straddle zero
    always_comb begin
        if (sign_a != sign_b) begin
            rel.gt = sign_b;
            rel.lt = sign_a;
            rel.eq = 1'b0;
        end else begin
            rel.gt = u_gt;
            rel.lt = u_lt;
            rel.eq = u_eq;
        end
    end

endmodule

// File: rtl/bus_word_cmp.sv
module bus_word_cmp
    import cmp_seq_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [WIDTH-1:0] bus_word,
    output logic             gt_o,
    output logic             lt_o,
    output logic             eq_o,
    output logic             valid_o
);

    localparam int SIGN = WIDTH - 1;

    cmp_state_t       state;
    logic             cap_a, cap_b, publish;
    logic [WIDTH-1:0] opnd_a, opnd_b;
    cmp_flags_t       rel_now, rel_q;

    cmp_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .state   (state),
        .cap_a   (cap_a),
        .cap_b   (cap_b),
        .publish (publish)
    );

    // operand registers
    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_a <= '0;
            opnd_b <= '0;
        end else begin
            if (cap_a) opnd_a <= bus_word;
            if (cap_b) opnd_b <= bus_word;
        end
    end

    cmp_mag_core #(.WIDTH(WIDTH)) u_core (
        .op_a (opnd_a),
        .op_b (opnd_b),
        .rel  (rel_now)
    );

    // result register
    always_ff @(posedge clk) begin
        if (rst) begin
            rel_q   <= '0;
            valid_o <= 1'b0;
        end else if (trig) begin
            rel_q   <= '0;
            valid_o <= 1'b0;
        end else if (publish) begin
            rel_q   <= rel_now;
            valid_o <= 1'b1;
        end
    end

    assign gt_o = rel_q.gt;
    assign lt_o = rel_q.lt;
    assign eq_o = rel_q.eq;

    // R4
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $countones({gt_o, lt_o, eq_o}) == 1);

    // R4
    quiet_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ({gt_o, lt_o, eq_o} == 3'b000));

    // R9
    hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !trig) |=> ($stable({gt_o, lt_o, eq_o}) && valid_o));

    // R11
    trig_clears_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> !valid_o);

    // R6
    neg_first_chk: assert property (@(posedge clk) disable iff (rst)
        (publish && opnd_a[SIGN] && !opnd_b[SIGN]) |=> (lt_o && !gt_o && !eq_o));

    // R7
    neg_second_chk: assert property (@(posedge clk) disable iff (rst)
        (publish && !opnd_a[SIGN] && opnd_b[SIGN]) |=> (gt_o && !lt_o && !eq_o));

endmodule

// File: tb/bus_word_cmp_tb_top.sv
module bus_word_cmp_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         trig = 1'b0;
    logic [W-1:0] bus_word = '0;
    logic         gt_o, lt_o, eq_o, valid_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    bus_word_cmp #(.WIDTH(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .bus_word (bus_word),
        .gt_o     (gt_o),
        .lt_o     (lt_o),
        .eq_o     (eq_o),
        .valid_o  (valid_o)
    );

    function automatic logic [2:0] exp_flags(input logic [W-1:0] a, input logic [W-1:0] b);
        if ($signed(a) > $signed(b))      return 3'b100;
        else if ($signed(a) < $signed(b)) return 3'b010;
        else                              return 3'b001;
    endfunction

    function automatic string req_of(input logic [W-1:0] a, input logic [W-1:0] b);
        if (a == b)                  return "R8";
        if (a[W-1] && !b[W-1])       return "R6";
        if (!a[W-1] && b[W-1])       return "R7";
        return "R5";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // trigger, feed a then b, check valid low before and flags at edge E+3
    task automatic run_cmp(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk); trig = 1'b1; bus_word = W'($urandom);
        @(negedge clk); trig = 1'b0; bus_word = a;
        @(negedge clk); bus_word = b;
        @(negedge clk); bus_word = W'($urandom);
        chk(valid_o == 1'b0, "R3", "valid before E+3", 32'(valid_o), 32'd0);
        @(negedge clk);
        chk(valid_o == 1'b1, "R3", "valid at E+3", 32'(valid_o), 32'd1);
        chk({gt_o, lt_o, eq_o} == exp_flags(a, b), req_of(a, b), "flags (R2 order)",
            32'({gt_o, lt_o, eq_o}), 32'(exp_flags(a, b)));
        chk($countones({gt_o, lt_o, eq_o}) == 1, "R4", "one-hot", 32'({gt_o, lt_o, eq_o}), 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0] held;
        logic [W-1:0] a, b;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        // R1
        chk({gt_o, lt_o, eq_o, valid_o} == 4'b0, "R1", "in reset",
            32'({gt_o, lt_o, eq_o, valid_o}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({gt_o, lt_o, eq_o, valid_o} == 4'b0, "R1", "after reset",
            32'({gt_o, lt_o, eq_o, valid_o}), 32'd0);

        // directed corners across the sign boundary
        run_cmp(16'h8000, 16'h7FFF);   // R6
        run_cmp(16'h7FFF, 16'h8000);   // R7
        run_cmp(16'hFFFF, 16'h0000);   // R6
        run_cmp(16'h0000, 16'hFFFF);   // R7
        run_cmp(16'h8000, 16'h8000);   // R8
        run_cmp(16'hFFFF, 16'hFFFE);   // R5
        run_cmp(16'h0001, 16'h0002);   // R5, R2 order
        run_cmp(16'h0002, 16'h0001);   // R5, R2 order

        // R9: hold while bus changes
        held = {gt_o, lt_o, eq_o};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); bus_word = W'($urandom);
        end
        @(negedge clk);
        chk({gt_o, lt_o, eq_o} == held && valid_o, "R9", "held flags",
            32'({valid_o, gt_o, lt_o, eq_o}), 32'({1'b1, held}));

        // R11: trigger clears
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0; bus_word = 16'h0005;
        chk({gt_o, lt_o, eq_o, valid_o} == 4'b0, "R11", "cleared by trigger",
            32'({gt_o, lt_o, eq_o, valid_o}), 32'd0);
        @(negedge clk); bus_word = 16'h0005;
        @(negedge clk); bus_word = 16'h1234;
        @(negedge clk);
        chk(eq_o && valid_o, "R8", "equal after clear", 32'({gt_o, lt_o, eq_o}), 32'b001);

        // R10: restart during second capture
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0; bus_word = 16'h0001;
        @(negedge clk); trig = 1'b1; bus_word = 16'h7000;
        @(negedge clk); trig = 1'b0; bus_word = 16'h9000;
        @(negedge clk); bus_word = 16'h0003;
        @(negedge clk); bus_word = 16'h0000;
        chk(valid_o == 1'b0, "R10", "no publish before restart result", 32'(valid_o), 32'd0);
        @(negedge clk);
        chk({gt_o, lt_o, eq_o} == 3'b010 && valid_o, "R10", "restart operands",
            32'({gt_o, lt_o, eq_o}), 32'b010);

        // R10: restart during settle suppresses the abandoned result
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0; bus_word = 16'h0009;
        @(negedge clk); bus_word = 16'h0001;
        @(negedge clk); trig = 1'b1; bus_word = 16'h0000;
        @(negedge clk); trig = 1'b0; bus_word = 16'h0002;
        chk(valid_o == 1'b0, "R10", "abandoned not published", 32'(valid_o), 32'd0);
        @(negedge clk); bus_word = 16'h0002;
        @(negedge clk); bus_word = 16'hAAAA;
        @(negedge clk);
        chk({gt_o, lt_o, eq_o} == 3'b001 && valid_o, "R10", "fresh result after settle restart",
            32'({gt_o, lt_o, eq_o}), 32'b001);

        // constrained random mix
        for (int n = 0; n < 80; n++) begin
            a = W'($urandom);
            b = W'($urandom);
            case (n % 4)
                0: b = a;
                1: b[W-1] = a[W-1];
                2: b[W-1] = ~a[W-1];
                default: ;
            endcase
            run_cmp(a, b);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule